// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for thirteen pins. Software reaches it through a simple byte-wide port. It has an address, a write strobe, write data and a combinational read-data bus. Each pin has one output-control register and one input-control register. The output-control register sets the pin's direction, its drive style, its output level and the pull-resistor select bits. The input-control register chooses which edges of the pin raise an interrupt and reads back the pin's level.

Every pad input passes through a two-flop synchroniser. An edge is detected by comparing the synchronised level with its value one cycle earlier. A detected edge latches a pending bit. The pending bits are split into two groups of unequal size: pins 0–6 form the low group and pins 7–12 form the high group. Each group has its own status register and its own mask register. One interrupt line is raised whenever any pending bit whose mask bit is clear is set. Software clears pending bits by writing ones back to the status register.

The pad outputs are the output value, an output enable, a push-pull flag, a pull enable and a two-bit pull select for each pin. The analog pad drivers and the resistors themselves are outside the block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: On reset every register is 0, so every pin is an input, edge detection is off, all status and mask bits are 0, every pad_oe bit is 0 and irq is 0.
- R2: The output-control register of pin p is at address p (0–12). Its fields are: bit 5 direction (1 = output), bit 4 drive (1 = push-pull, 0 = open-drain), bit 3 pull enable, bits 2:1 pull select and bit 0 output level. A write stores bits 5:0, and bits 7:6 read back as 0.
- R3: pad_out, pad_push_pull, pad_pull_en and pad_pull_sel[2p+1:2p] follow the stored fields of pin p. pad_oe is 0 for an input pin and 1 for a push-pull output pin. For an open-drain output pin, pad_oe is 1 only while the output level is 0.
- R4: The input-control register of pin p is at address 13+p. Bit 0 reads the pin level after the two-flop synchroniser, so a change on pad_in appears there two clocks later. Bits 2:1 hold the edge mode. Bits 7:3 read as 0, and a write changes only bits 2:1.
- R5: Edge mode 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge sets the pin's status bit on the third rising clock after the pad changes.
- R6: Status for pins 0–6 is read at address 26 as bits 6:0, and status for pins 7–12 at address 27 as bits 5:0. The unused upper bits read 0.
- R7: The mask registers are at addresses 28 (pins 0–6) and 29 (pins 7–12) with the same bit layout as status. A mask bit of 1 blocks that pin from irq but does not stop its status bit from being set. irq is the OR over all pins of status AND NOT mask.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R9: If an edge sets a status bit in the same cycle as a write of 1 to that bit, the bit stays set.
- R10: Reads of addresses 30–63 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_in | input | 13 | Asynchronous pad levels |
| pad_out | output | 13 | Output level per pin |
| pad_oe | output | 13 | Output driver enable per pin |
| pad_push_pull | output | 13 | 1 = push-pull, 0 = open-drain |
| pad_pull_en | output | 13 | Pull resistor enable per pin |
| pad_pull_sel | output | 26 | Pull select, two bits per pin |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions check the following on every cycle:
- An input pin never drives its pad.
- A disabled edge mode never produces a hit.
- irq never rises without a pending status bit.
- A write of ones clears the low-group status when no edge competes with it.
- A freshly detected edge is always latched.

The bench's scenarios are needed to show behaviour that depends on timing and layout:
- The two-clock synchroniser latency.
- The falling, rising and both-edge selections.
- The open-drain enable.
- The split of pins between the two status groups.
- Set-wins-over-clear with a real pad edge timed against the write.
- Silence at unmapped addresses.

A cycle-accurate reference model compares every output and the read bus on every clock while these scenarios and a pseudo-random stretch run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic       dir;
        logic       push_pull;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } out_ctrl_t;

    function automatic logic edge_hit(edge_mode_e m, logic cur, logic prv);
        case (m)
            EDGE_FALL: return prv & ~cur;
            EDGE_RISE: return cur & ~prv;
            EDGE_BOTH: return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic drive_enable(out_ctrl_t c);
        return c.dir & (c.push_pull | ~c.level);
    endfunction

endpackage

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pad,
    input  edge_mode_e mode,
    output logic       level,
    output logic       hit
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign hit   = edge_hit(mode, sync_q, prev_q);
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hit,
    input  logic             wr_status,
    input  logic             wr_mask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask,
    output logic             pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            // a new hit outranks a same-cycle clear
            status <= (status & ~(wr_status ? wdata : '0)) | hit;
            if (wr_mask) mask <= wdata;
        end
    end

    assign pend = |(status & ~mask);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 13,
    parameter int GROUP0_PINS = 7,
    parameter int ADDR_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_push_pull,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [2*NUM_PINS-1:0] pad_pull_sel,
    output logic                  irq
);
    localparam int GROUP1_PINS = NUM_PINS - GROUP0_PINS;
    localparam int IC_BASE     = NUM_PINS;
    localparam int STAT0_ADDR  = 2 * NUM_PINS;
    localparam int STAT1_ADDR  = STAT0_ADDR + 1;
    localparam int MASK0_ADDR  = STAT0_ADDR + 2;
    localparam int MASK1_ADDR  = STAT0_ADDR + 3;
    localparam int OC_W        = $bits(out_ctrl_t);

    logic [NUM_PINS-1:0]      dir_vec, hit_vec, level_vec;
    logic [2*NUM_PINS-1:0]    mode_vec;
    logic [OC_W*NUM_PINS-1:0] oc_flat;
    logic [NUM_PINS-1:0]      stat_vec, mask_vec;
    logic                     pend0, pend1;
    logic                     unused_wdata;

    assign unused_wdata = reg_wdata[7];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        out_ctrl_t  oc_q;
        edge_mode_e md_q;
        logic       wr_oc, wr_ic;

        assign wr_oc = reg_wr && (reg_addr == ADDR_W'(p));
        assign wr_ic = reg_wr && (reg_addr == ADDR_W'(IC_BASE + p));

        always_ff @(posedge clk) begin
            if (rst) begin
                oc_q <= '0;
                md_q <= EDGE_OFF;
            end else begin
                if (wr_oc) oc_q <= out_ctrl_t'(reg_wdata[OC_W-1:0]);
                if (wr_ic) md_q <= edge_mode_e'(reg_wdata[2:1]);
            end
        end

        gpio_pin_sense u_sense (
            .clk   (clk),
            .rst   (rst),
            .pad   (pad_in[p]),
            .mode  (md_q),
            .level (level_vec[p]),
            .hit   (hit_vec[p])
        );

        assign oc_flat[OC_W*p +: OC_W] = oc_q;
        assign mode_vec[2*p +: 2]      = md_q;
        assign dir_vec[p]              = oc_q.dir;
        assign pad_out[p]              = oc_q.level;
        assign pad_push_pull[p]        = oc_q.push_pull;
        assign pad_pull_en[p]          = oc_q.pull_en;
        assign pad_pull_sel[2*p +: 2]  = oc_q.pull_sel;
        assign pad_oe[p]               = drive_enable(oc_q);
    end

    gpio_irq_group #(.WIDTH(GROUP0_PINS)) u_grp0 (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit_vec[GROUP0_PINS-1:0]),
        .wr_status (reg_wr && reg_addr == ADDR_W'(STAT0_ADDR)),
        .wr_mask   (reg_wr && reg_addr == ADDR_W'(MASK0_ADDR)),
        .wdata     (reg_wdata[GROUP0_PINS-1:0]),
        .status    (stat_vec[GROUP0_PINS-1:0]),
        .mask      (mask_vec[GROUP0_PINS-1:0]),
        .pend      (pend0)
    );

    gpio_irq_group #(.WIDTH(GROUP1_PINS)) u_grp1 (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit_vec[NUM_PINS-1:GROUP0_PINS]),
        .wr_status (reg_wr && reg_addr == ADDR_W'(STAT1_ADDR)),
        .wr_mask   (reg_wr && reg_addr == ADDR_W'(MASK1_ADDR)),
        .wdata     (reg_wdata[GROUP1_PINS-1:0]),
        .status    (stat_vec[NUM_PINS-1:GROUP0_PINS]),
        .mask      (mask_vec[NUM_PINS-1:GROUP0_PINS]),
        .pend      (pend1)
    );

    assign irq = pend0 | pend1;

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (reg_addr == ADDR_W'(p))
                reg_rdata = DATA_W'(oc_flat[OC_W*p +: OC_W]);
            if (reg_addr == ADDR_W'(IC_BASE + p))
                reg_rdata = DATA_W'({mode_vec[2*p +: 2], level_vec[p]});
        end
        if (reg_addr == ADDR_W'(STAT0_ADDR)) reg_rdata = DATA_W'(stat_vec[GROUP0_PINS-1:0]);
        if (reg_addr == ADDR_W'(STAT1_ADDR)) reg_rdata = DATA_W'(stat_vec[NUM_PINS-1:GROUP0_PINS]);
        if (reg_addr == ADDR_W'(MASK0_ADDR)) reg_rdata = DATA_W'(mask_vec[GROUP0_PINS-1:0]);
        if (reg_addr == ADDR_W'(MASK1_ADDR)) reg_rdata = DATA_W'(mask_vec[NUM_PINS-1:GROUP0_PINS]);
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_PINS    = 13,
    parameter int GROUP0_PINS = 7,
    parameter int ADDR_W      = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [7:0]            reg_wdata,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic                  irq,
    input logic [NUM_PINS-1:0]   dir_vec,
    input logic [NUM_PINS-1:0]   hit_vec,
    input logic [2*NUM_PINS-1:0] mode_vec,
    input logic [NUM_PINS-1:0]   stat_vec,
    input logic [NUM_PINS-1:0]   mask_vec
);
    localparam int STAT0_ADDR = 2 * NUM_PINS;

    logic unused_chk;
    assign unused_chk = ^reg_wdata[7:GROUP0_PINS];

    // R1: reset leaves status, mask and drivers cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (stat_vec == '0 && mask_vec == '0 && pad_oe == '0))
        else $error("a_r1_reset_clear");

    // R3: an input pin never drives its pad
    a_r3_input_no_drive: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~dir_vec) == '0)
        else $error("a_r3_input_no_drive");

    // R5: edge mode 0 never yields a hit
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_off
        a_r5_off_no_hit: assert property (@(posedge clk) disable iff (rst)
            (mode_vec[2*i +: 2] == 2'd0) |-> !hit_vec[i])
            else $error("a_r5_off_no_hit");
    end

    // R7: irq needs at least one pending status bit
    a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_vec != '0))
        else $error("a_r7_irq_needs_status");

    // R8: writing ones clears the low group when no edge competes
    a_r8_w1c_low: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(STAT0_ADDR) && hit_vec[GROUP0_PINS-1:0] == '0)
        |=> ((stat_vec[GROUP0_PINS-1:0] & $past(reg_wdata[GROUP0_PINS-1:0])) == '0))
        else $error("a_r8_w1c_low");

    // R9: every hit is latched, even against a clear
    a_r9_hit_latched: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |=> ((stat_vec & $past(hit_vec)) == $past(hit_vec)))
        else $error("a_r9_hit_latched");
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .NUM_PINS    (NUM_PINS),
    .GROUP0_PINS (GROUP0_PINS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .dir_vec   (dir_vec),
    .hit_vec   (hit_vec),
    .mode_vec  (mode_vec),
    .stat_vec  (stat_vec),
    .mask_vec  (mask_vec)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 13;
    localparam int G0 = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_push_pull, pad_pull_en;
    logic [2*NP-1:0] pad_pull_sel;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_push_pull(pad_push_pull),
        .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel), .irq(irq)
    );

    // reference model state
    logic [5:0]    m_oc [NP];
    logic [1:0]    m_md [NP];
    logic [NP-1:0] m_s1, m_s2, m_prev, m_st, m_mk;

    always @(posedge clk) begin : model
        logic [NP-1:0] set_v, clr_v;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin m_oc[i] = '0; m_md[i] = '0; end
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_mk = '0;
        end else begin
            set_v = '0;
            clr_v = '0;
            for (int i = 0; i < NP; i++) begin
                case (m_md[i])
                    2'd1: set_v[i] = m_prev[i] && !m_s2[i];
                    2'd2: set_v[i] = !m_prev[i] && m_s2[i];
                    2'd3: set_v[i] = m_prev[i] != m_s2[i];
                    default: set_v[i] = 1'b0;
                endcase
            end
            if (reg_wr) begin
                if (reg_addr < NP) m_oc[reg_addr] = reg_wdata[5:0];
                else if (reg_addr < 2*NP) m_md[reg_addr-NP] = reg_wdata[2:1];
                else if (reg_addr == 26) clr_v[6:0] = reg_wdata[6:0];
                else if (reg_addr == 27) clr_v[12:7] = reg_wdata[5:0];
                else if (reg_addr == 28) m_mk[6:0] = reg_wdata[6:0];
                else if (reg_addr == 29) m_mk[12:7] = reg_wdata[5:0];
            end
            m_st   = (m_st & ~clr_v) | set_v;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        if (a < NP)   return {2'b0, m_oc[a]};
        if (a < 2*NP) return {5'b0, m_md[a-NP], m_s2[a-NP]};
        case (a)
            6'd26: return {1'b0, m_st[6:0]};
            6'd27: return {2'b0, m_st[12:7]};
            6'd28: return {1'b0, m_mk[6:0]};
            6'd29: return {2'b0, m_mk[12:7]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [5:0] a);
        if (a < NP)   return "R2";
        if (a < 2*NP) return "R4";
        if (a < 28)   return "R6";
        if (a < 30)   return "R7";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s phase) %s: actual %0h expected %0h", tag, phase, what, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!finished) begin : cmp
            logic [NP-1:0] e_out, e_oe, e_pp, e_pe;
            logic [2*NP-1:0] e_ps;
            for (int i = 0; i < NP; i++) begin
                e_out[i] = m_oc[i][0];
                e_pp[i]  = m_oc[i][4];
                e_pe[i]  = m_oc[i][3];
                e_ps[2*i +: 2] = m_oc[i][2:1];
                e_oe[i]  = m_oc[i][5] && (m_oc[i][4] || !m_oc[i][0]);
            end
            check("R3", "pad_out", 32'(pad_out), 32'(e_out));
            check("R3", "pad_oe", 32'(pad_oe), 32'(e_oe));
            check("R3", "pad_push_pull", 32'(pad_push_pull), 32'(e_pp));
            check("R3", "pad_pull_en", 32'(pad_pull_en), 32'(e_pe));
            check("R3", "pad_pull_sel", 32'(pad_pull_sel), 32'(e_ps));
            check("R7", "irq", 32'(irq), 32'(|(m_st & ~m_mk)));
            check(rd_tag(reg_addr), "reg_rdata", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a);
        @(negedge clk);
        reg_addr = a;
    endtask

    task automatic set_pad(input logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        phase = "R1";
        idle(4);
        rst = 1'b0;
        // R1 / R10: sweep every address after reset
        for (int a = 0; a < 64; a++) peek(6'(a));

        // R2: output-control fields, upper bits dropped
        phase = "R2";
        for (int p = 0; p < NP; p++) wr_reg(6'(p), 8'(8'hC0 | (p * 5)));
        for (int p = 0; p < NP; p++) peek(6'(p));

        // R3: drive combinations
        phase = "R3";
        wr_reg(6'd0, 8'h31);   // push-pull output high
        wr_reg(6'd1, 8'h30);   // push-pull output low
        wr_reg(6'd2, 8'h21);   // open-drain output high: released
        wr_reg(6'd3, 8'h20);   // open-drain output low: driven
        wr_reg(6'd4, 8'h1F);   // input with push-pull flag set
        idle(2);
        wr_reg(6'd2, 8'h20);
        idle(1);

        // R4: synchronised level and mode bits
        phase = "R4";
        wr_reg(6'd13, 8'hFF);
        set_pad(13'h1555);
        peek(6'd13); peek(6'd14); peek(6'd15); peek(6'd25);
        set_pad(13'h0AAA);
        peek(6'd13); peek(6'd14); peek(6'd24);
        wr_reg(6'd13, 8'h00);
        set_pad('0);
        idle(4);

        // R5: each edge mode
        phase = "R5";
        wr_reg(6'd15, 8'h02);  // pin 2 falling
        wr_reg(6'd22, 8'h04);  // pin 9 rising
        wr_reg(6'd25, 8'h06);  // pin 12 both
        wr_reg(6'd17, 8'h00);  // pin 4 off
        peek(6'd26);
        set_pad(13'h1214);     // rise on 2,4,9,12
        idle(4); peek(6'd27); idle(1); peek(6'd26);
        set_pad(13'h0000);     // fall on 2,4,9,12
        idle(4); peek(6'd26); idle(1); peek(6'd27);

        // R6: group layout reads
        phase = "R6";
        peek(6'd26); peek(6'd27);

        // R7: masking
        phase = "R7";
        wr_reg(6'd28, 8'h7F);
        wr_reg(6'd29, 8'h3F);
        peek(6'd28); peek(6'd29);
        wr_reg(6'd29, 8'h00);
        idle(1);
        wr_reg(6'd29, 8'h20);
        peek(6'd27);

        // R8: partial write-one-to-clear
        phase = "R8";
        wr_reg(6'd27, 8'h01);
        peek(6'd27);
        wr_reg(6'd27, 8'h00);
        peek(6'd27);
        wr_reg(6'd26, 8'h7F);
        wr_reg(6'd27, 8'hFF);
        peek(6'd26); peek(6'd27);
        wr_reg(6'd29, 8'h00);

        // R9: edge in the same cycle as its clear
        phase = "R9";
        set_pad(13'h1000);
        idle(4);
        set_pad(13'h0000);
        idle(1);
        wr_reg(6'd27, 8'h20);
        peek(6'd27);
        idle(2);

        // R10: unmapped writes have no effect
        phase = "R10";
        for (int a = 30; a < 64; a++) wr_reg(6'(a), 8'hFF);
        for (int a = 0; a < 64; a += 3) peek(6'(a));

        // mixed stretch
        phase = "R5";
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h5)
                wr_reg(6'(lfsr[9:4] % 32), lfsr[15:8]);
            else if (lfsr[2:0] == 3'd2)
                set_pad(lfsr[12:0] ^ lfsr[15:3]);
            else
                peek(6'(lfsr[10:5] % 32));
        end
        idle(3);
        finish_run();
    end
endmodule